// File: doc/BRIEF.md
# Multichannel Descriptor DMA Engine

This block moves data between memory locations on behalf of sixteen channels, using one shared transfer engine. Every channel has a transfer descriptor, and all descriptors sit in a small on-chip RAM instead of in per-channel flip-flops. When a channel is picked, the engine reads its descriptor from the RAM and works out the source and destination addresses. It runs read and write cycles on a simple 32-bit memory port. When it finishes, it writes the changed count and position back into the RAM, so the next service of that channel continues from where this one stopped.

Software programs descriptors through a word-wide configuration port. The same port is used to start channels by software and to clear completion flags. A channel can also be started in two more ways: by a level on its hardware request input (from a peripheral or a periodic timer), or by another channel that finishes and is set to link to it. Each channel has a done flag and an interrupt output. The interrupt output is raised only when the channel's interrupt-enable bit was set.

The engine is a five-state machine:
- ST_IDLE accepts the lowest-numbered pending channel and starts the descriptor read. The transition is take.
- ST_FETCH loads the descriptor. It returns to ST_IDLE when the byte count is zero, or goes on to ST_READ.
- ST_READ holds a read until the memory port is ready, then moves to ST_WRITE.
- ST_WRITE holds a write until the port is ready. It then loops back to ST_READ (block continue), or goes to ST_WBACK.
- ST_WBACK writes the descriptor back once the configuration port is not writing a descriptor, then returns to ST_IDLE.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, done_o and irq_o are all zero and mem_req is low.
- R2: Size code 0 moves one byte, code 1 moves a halfword, and codes 2 and 3 move a 32-bit word. Placement is little-endian. The unit is taken from the source byte lanes given by src address bits [1:0]. It is written to the lanes given by dst address bits [1:0], and mem_be covers exactly those lanes (mask 1, 3 or F shifted left by dst[1:0]).
- R3: Control bit 2 makes the source address post-increment, and control bit 3 does the same for the destination. Each address is base plus the descriptor position when its bit is set, and equals its base when the bit is clear.
- R4: The position (control word bits [31:16]) advances by the unit size after each write. It returns to zero when it reaches the nonzero wrap length in descriptor word 2 bits [31:16]. A wrap length of 0 means no wrap.
- R5: With control bit 4 clear (single mode), a service moves one unit. With it set (block mode), a service moves units until the byte count in word 2 bits [15:0] reaches zero.
- R6: When several channels are pending together, the lowest-numbered one is served first.
- R7: A channel becomes pending in any of three ways: its req_i bit is high; its bit is set in a write to cfg_addr 7'h40 (software start); or a channel with link enable (control bit 6) completes and names it in control bits [11:8].
- R8: When a channel's byte count reaches zero, its done bit is set. Its irq_o bit also rises if control bit 5 is set. Writing a one to the matching bit at cfg_addr 7'h41 clears both. A done bit never falls without that write.
- R9: While mem_ready is low, mem_req, mem_we, mem_addr, mem_wdata and mem_be hold their values.
- R10: The count and position are written back after each service, so a later request continues from where the last one stopped.
- R11: A request to a channel whose byte count is zero causes no bus cycle and leaves its done bit unchanged.
- R12: One channel is serviced at a time, and a block transfer is never interleaved with another channel's cycles. The descriptor RAM never receives a configuration write and a writeback in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Bit 6 clear: descriptor word {ch[3:0], word[1:0]}. Bit 6 set: bit 0 selects start (0) or done clear (1) |
| cfg_wdata | input | 32 | Configuration write data |
| req_i | input | 16 | Hardware request levels, one per channel |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, already placed in its byte lanes |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Completes the current cycle |
| done_o | output | 16 | Per-channel completion flags |
| irq_o | output | 16 | Per-channel interrupt requests |

## Verification
The assertions assume a well-behaved environment. Source and destination addresses are aligned to the unit size, and byte counts and wrap lengths are multiples of it. The memory responder keeps mem_rdata valid in the cycle it raises mem_ready. Descriptors are only rewritten while their channel is idle. The directed stimulus uses aligned addresses throughout. It changes descriptors only after the affected channel has reported done or before it is requested, and its memory model adds stall cycles without ever dropping a request.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int LANE_W    = 32;
    localparam int NUM_LANES = 4;
    localparam int CNT_W     = 16;
    localparam int DESC_W    = NUM_LANES * LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } eng_state_t;

    // control word of a descriptor (word 3)
    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [3:0]       rsv_hi;
        logic [3:0]       link_ch;
        logic             rsv_lo;
        logic             link_en;
        logic             irq_en;
        logic             block;
        logic             dinc;
        logic             sinc;
        logic [1:0]       size;
    } desc_ctl_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] unit_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dma_desc_ram.sv
module dma_desc_ram #(
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [W-1:0]      rdata,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata
);

    // one storage array per lane so each lane has its own write enable
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (re) begin
                rd_q <= store[raddr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
            end
        end
    end

    assign any_o = |req_i;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((grant_o & ~req_i) == '0) && (any_o == (grant_o != '0))); // R6

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    // pending selection
    input  logic              pend_any,
    input  logic [CH_W-1:0]   pend_idx,
    output logic              take_o,
    // descriptor RAM
    output logic              ram_re,
    output logic [CH_W-1:0]   ram_raddr,
    input  logic [DESC_W-1:0] ram_rdata,
    input  logic              cfg_busy,
    output logic              wb_we,
    output logic [CH_W-1:0]   wb_addr,
    output logic [LANE_W-1:0] wb_word2,
    output logic [LANE_W-1:0] wb_word3,
    // completion
    output logic              fin_o,
    output logic [CH_W-1:0]   fin_ch,
    output logic              fin_irq,
    output logic              fin_link_en,
    output logic [CH_W-1:0]   fin_link_ch,
    // memory port
    output logic              mem_req,
    output logic              mem_we,
    output logic [LANE_W-1:0] mem_addr,
    output logic [LANE_W-1:0] mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [LANE_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    eng_state_t state_q, state_d;

    desc_ctl_t          ctl_q;
    desc_ctl_t          fetch_ctl;
    logic [LANE_W-1:0]  src_q, dst_q, data_q;
    logic [CNT_W-1:0]   cnt_q, wrap_q;
    logic [CH_W-1:0]    ch_q;

    logic [CNT_W-1:0]   step, cnt_nxt, pos_nxt, fetch_cnt;
    logic [CNT_W:0]     pos_sum;
    logic [LANE_W-1:0]  src_addr, dst_addr;

    assign fetch_ctl = ram_rdata[4*LANE_W-1 -: LANE_W];
    assign fetch_cnt = ram_rdata[2*LANE_W +: CNT_W];

    // address and count arithmetic
    always_comb begin
        step     = CNT_W'(unit_bytes(ctl_q.size));
        pos_sum  = {1'b0, ctl_q.pos} + {1'b0, step};
        pos_nxt  = ((wrap_q != '0) && (pos_sum >= {1'b0, wrap_q})) ? '0 : pos_sum[CNT_W-1:0];
        cnt_nxt  = (cnt_q > step) ? (cnt_q - step) : '0;
        src_addr = src_q + (ctl_q.sinc ? LANE_W'(ctl_q.pos) : '0);
        dst_addr = dst_q + (ctl_q.dinc ? LANE_W'(ctl_q.pos) : '0);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        take_o    = 1'b0;
        ram_re    = 1'b0;
        ram_raddr = pend_idx;
        wb_we     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_addr;
        mem_wdata = data_q << {dst_addr[1:0], 3'b000};
        mem_be    = 4'(unit_mask(ctl_q.size) << dst_addr[1:0]);
        unique case (state_q)
            ST_IDLE: begin
                if (pend_any) begin
                    take_o  = 1'b1;
                    ram_re  = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                state_d = (fetch_cnt == '0) ? ST_IDLE : ST_READ;
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_addr;
                if (mem_ready) begin
                    state_d = ((cnt_nxt == '0) || !ctl_q.block) ? ST_WBACK : ST_READ;
                end
            end
            ST_WBACK: begin
                if (!cfg_busy) begin
                    wb_we   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // working copy of the active descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            wrap_q <= '0;
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            if (take_o) begin
                ch_q <= pend_idx;
            end
            if (state_q == ST_FETCH) begin
                src_q  <= ram_rdata[0 +: LANE_W];
                dst_q  <= ram_rdata[LANE_W +: LANE_W];
                cnt_q  <= fetch_cnt;
                wrap_q <= ram_rdata[2*LANE_W+CNT_W +: CNT_W];
                ctl_q  <= fetch_ctl;
            end
            if ((state_q == ST_READ) && mem_ready) begin
                data_q <= mem_rdata >> {src_addr[1:0], 3'b000};
            end
            if ((state_q == ST_WRITE) && mem_ready) begin
                cnt_q     <= cnt_nxt;
                ctl_q.pos <= pos_nxt;
            end
        end
    end

    assign wb_addr     = ch_q;
    assign wb_word2    = {wrap_q, cnt_q};
    assign wb_word3    = ctl_q;
    assign fin_o       = wb_we && (cnt_q == '0);
    assign fin_ch      = ch_q;
    assign fin_irq     = ctl_q.irq_en;
    assign fin_link_en = ctl_q.link_en;
    assign fin_link_ch = ctl_q.link_ch[CH_W-1:0];

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata) && $stable(mem_be)); // R9

    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})); // R2

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CFG_AW = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [NUM_CH-1:0] req_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] done_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] pend_q, done_q, ien_q;
    logic [NUM_CH-1:0] grant, take_mask, sw_mask, clr_mask, link_mask, fin_mask;
    logic [CH_W-1:0]   pend_idx;
    logic              pend_any, take;

    logic              desc_we, glob_we;
    logic [1:0]        cfg_word;
    logic [CH_W-1:0]   cfg_ch;

    logic              ram_re;
    logic [CH_W-1:0]   ram_raddr, ram_waddr, wb_addr;
    logic [DESC_W-1:0] ram_rdata, ram_wdata;
    logic [NUM_LANES-1:0] ram_we;
    logic              wb_we;
    logic [LANE_W-1:0] wb_word2, wb_word3;

    logic              fin, fin_irq, fin_link_en;
    logic [CH_W-1:0]   fin_ch, fin_link_ch;

    // configuration decode
    assign glob_we  = cfg_we && cfg_addr[CFG_AW-1];
    assign desc_we  = cfg_we && !cfg_addr[CFG_AW-1];
    assign cfg_word = cfg_addr[1:0];
    assign cfg_ch   = cfg_addr[CH_W+1:2];
    assign sw_mask  = (glob_we && !cfg_addr[0]) ? cfg_wdata[NUM_CH-1:0] : '0;
    assign clr_mask = (glob_we &&  cfg_addr[0]) ? cfg_wdata[NUM_CH-1:0] : '0;

    dma_arbiter #(.N(NUM_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pend_q),
        .grant_o (grant),
        .idx_o   (pend_idx),
        .any_o   (pend_any)
    );

    assign take_mask = take ? grant : '0;
    assign fin_mask  = fin ? (NUM_CH'(1) << fin_ch) : '0;
    assign link_mask = (fin && fin_link_en) ? (NUM_CH'(1) << fin_link_ch) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            done_q <= '0;
            ien_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~take_mask) | req_i | sw_mask | link_mask;
            done_q <= (done_q & ~clr_mask) | fin_mask;
            ien_q  <= (ien_q & ~clr_mask & ~fin_mask) | (fin_irq ? fin_mask : '0);
        end
    end

    assign done_o = done_q;
    assign irq_o  = done_q & ien_q;

    // descriptor RAM write port: configuration first, writeback waits
    always_comb begin
        if (desc_we) begin
            ram_we    = NUM_LANES'(1) << cfg_word;
            ram_waddr = cfg_ch;
            ram_wdata = {NUM_LANES{cfg_wdata}};
        end else begin
            ram_we    = wb_we ? 4'b1100 : 4'b0000;
            ram_waddr = wb_addr;
            ram_wdata = {wb_word3, wb_word2, {(2*LANE_W){1'b0}}};
        end
    end

    dma_desc_ram #(.DEPTH(NUM_CH), .LANES(NUM_LANES), .LANE_W(LANE_W)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata)
    );

    dma_engine #(.NUM_CH(NUM_CH)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_any    (pend_any),
        .pend_idx    (pend_idx),
        .take_o      (take),
        .ram_re      (ram_re),
        .ram_raddr   (ram_raddr),
        .ram_rdata   (ram_rdata),
        .cfg_busy    (desc_we),
        .wb_we       (wb_we),
        .wb_addr     (wb_addr),
        .wb_word2    (wb_word2),
        .wb_word3    (wb_word3),
        .fin_o       (fin),
        .fin_ch      (fin_ch),
        .fin_irq     (fin_irq),
        .fin_link_en (fin_link_en),
        .fin_link_ch (fin_link_ch),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready)
    );

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_we && wb_we)); // R12

    for (genvar c = 0; c < NUM_CH; c++) begin : g_done_chk
        AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            $past(done_q[c]) && !$past(clr_mask[c]) |-> done_q[c]); // R8
    end

endmodule

// File: tb/dma_ctrl_tb.sv
module dma_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] req_i = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic [15:0] done_o, irq_o;

    int checks = 0;
    int errors = 0;

    // memory model with write log
    logic [31:0] mem [512];
    logic [3:0]  stall_cfg = '0;
    logic [3:0]  stall_cnt = '0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [3:0]  log_be   [64];
    int          wr_cnt = 0;

    always #4 clk = ~clk;

    dma_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .req_i     (req_i),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .done_o    (done_o),
        .irq_o     (irq_o)
    );

    assign mem_ready = mem_req && (stall_cnt == 4'd0);
    assign mem_rdata = mem[mem_addr[10:2]];

    always @(posedge clk) begin
        if (mem_req) begin
            if (stall_cnt != 4'd0) begin
                stall_cnt <= stall_cnt - 4'd1;
            end else begin
                stall_cnt <= stall_cfg;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++) begin
                        if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    end
                    if (wr_cnt < 64) begin
                        log_addr[wr_cnt] <= mem_addr;
                        log_data[wr_cnt] <= mem_wdata;
                        log_be[wr_cnt]   <= mem_be;
                    end
                    wr_cnt <= wr_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_desc(input int ch, input logic [31:0] src, input logic [31:0] dst,
                            input logic [15:0] cnt, input logic [15:0] wrap, input logic [31:0] ctl);
        cfg_write({1'b0, 4'(ch), 2'd0}, src);
        cfg_write({1'b0, 4'(ch), 2'd1}, dst);
        cfg_write({1'b0, 4'(ch), 2'd2}, {wrap, cnt});
        cfg_write({1'b0, 4'(ch), 2'd3}, ctl);
    endtask

    task automatic pulse_req(input logic [15:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic wait_done(input int ch);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_o[ch]) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 done", 32'(done_o), 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 mem_req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_word_block();
        for (int i = 0; i < 4; i++) mem[9'h40 + 9'(i)] = 32'hA000_0000 + 32'(i * 32'h111);
        set_desc(0, 32'h100, 32'h200, 16'd16, 16'd0, 32'h3E);
        cfg_write(7'h40, 32'h1);
        wait_done(0);
        for (int i = 0; i < 4; i++)
            chk("R2 R3 R5 word block data", mem[9'h80 + 9'(i)], 32'hA000_0000 + 32'(i * 32'h111));
        chk("R8 done ch0", 32'(done_o[0]), 32'h1);
        chk("R8 irq ch0", 32'(irq_o[0]), 32'h1);
        cfg_write(7'h41, 32'h1);
        @(negedge clk);
        chk("R8 clear done ch0", 32'(done_o[0]), 32'h0);
        chk("R8 clear irq ch0", 32'(irq_o[0]), 32'h0);
    endtask

    task automatic t_byte_single();
        logic [7:0] vals [4] = '{8'h5A, 8'h6B, 8'h7C, 8'h8D};
        int w0;
        set_desc(1, 32'h302, 32'h341, 16'd4, 16'd0, 32'h08);
        w0 = wr_cnt;
        for (int i = 0; i < 4; i++) begin
            mem[9'hC0] = {8'h00, vals[i], 16'h0000};
            pulse_req(16'h0002);
            repeat (20) @(negedge clk);
            chk("R5 R10 single mode one unit per request", 32'(wr_cnt - w0), 32'(i + 1));
            chk("R10 done only after last unit", 32'(done_o[1]), (i == 3) ? 32'h1 : 32'h0);
        end
        chk("R2 R3 byte lanes word0", mem[9'hD0], 32'h7C6B_5A00);
        chk("R2 R3 byte lanes word1", mem[9'hD1], 32'h0000_008D);
        chk("R8 irq disabled ch1", 32'(irq_o[1]), 32'h0);
    endtask

    task automatic t_half_wrap();
        int w0;
        mem[9'h100] = 32'hBBBB_AAAA;
        set_desc(2, 32'h400, 32'h482, 16'd8, 16'd4, 32'h15);
        w0 = wr_cnt;
        cfg_write(7'h40, 32'h4);
        wait_done(2);
        chk("R5 half block write count", 32'(wr_cnt - w0), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 wrap data", {16'h0, log_data[w0 + i][31:16]}, (i % 2 == 0) ? 32'hAAAA : 32'hBBBB);
            chk("R2 half be", 32'(log_be[w0 + i]), 32'hC);
            chk("R3 constant dst", log_addr[w0 + i], 32'h482);
        end
    endtask

    task automatic t_priority();
        int w0;
        for (int i = 0; i < 4; i++) mem[9'h40 + 9'(i)] = 32'hC000_0000 + 32'(i);
        set_desc(3, 32'h100, 32'h520, 16'd8, 16'd0, 32'h1E);
        set_desc(5, 32'h108, 32'h530, 16'd8, 16'd0, 32'h1E);
        w0 = wr_cnt;
        pulse_req(16'h0028);
        wait_done(5);
        wait_done(3);
        chk("R6 lowest first", log_addr[w0], 32'h520);
        chk("R12 no interleave", log_addr[w0 + 1], 32'h524);
        chk("R12 second channel after", log_addr[w0 + 2], 32'h530);
        chk("R6 R7 req data", mem[9'h14D], 32'hC000_0003);
    endtask

    task automatic t_link();
        set_desc(6, 32'h100, 32'h540, 16'd4, 16'd0, 32'h75E);
        set_desc(7, 32'h104, 32'h548, 16'd4, 16'd0, 32'h3E);
        cfg_write(7'h40, 32'h40);
        wait_done(7);
        chk("R7 link started ch7 data", mem[9'h152], 32'hC000_0001);
        chk("R7 ch6 done", 32'(done_o[6]), 32'h1);
        chk("R8 irq disabled ch6", 32'(irq_o[6]), 32'h0);
        chk("R8 irq enabled ch7", 32'(irq_o[7]), 32'h1);
    endtask

    task automatic t_stall();
        int w0;
        stall_cfg = 4'd3;
        set_desc(8, 32'h108, 32'h580, 16'd8, 16'd0, 32'h1E);
        w0 = wr_cnt;
        pulse_req(16'h0100);
        wait_done(8);
        chk("R9 stalled writes count", 32'(wr_cnt - w0), 32'd2);
        chk("R9 stalled data0", mem[9'h160], 32'hC000_0002);
        chk("R9 stalled data1", mem[9'h161], 32'hC000_0003);
        stall_cfg = 4'd0;
    endtask

    task automatic t_zero();
        int w0;
        set_desc(9, 32'h100, 32'h5C0, 16'd0, 16'd0, 32'h3E);
        w0 = wr_cnt;
        pulse_req(16'h0200);
        repeat (30) @(negedge clk);
        chk("R11 no bus cycle", 32'(wr_cnt - w0), 32'd0);
        chk("R11 done unchanged", 32'(done_o[9]), 32'h0);
    endtask

    task automatic t_clear_all();
        cfg_write(7'h41, 32'hFFFF);
        @(negedge clk);
        chk("R8 all done cleared", 32'(done_o), 32'h0);
        chk("R8 all irq cleared", 32'(irq_o), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_block();
        t_byte_single();
        t_half_wrap();
        t_priority();
        t_link();
        t_stall();
        t_zero();
        t_clear_all();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule